// File: doc/BRIEF.md
# PHY Management Serial Controller

This block runs single read or write transactions on the two-wire management bus of an external Ethernet PHY. Four word-wide registers are reached through a small register port. Software sets a clock divisor and an optional preamble skip in the control register. For a write it loads the 16-bit data register first. It then writes the command register with one operation bit, the PHY address and the register address. The block shifts out the serial frame on a management clock it derives from the system clock. The status register shows busy for the whole frame. When busy drops after a read, the data register holds the 16 bits returned by the PHY.

The frame is driven by a sequencer with six states. IDLE waits for a valid command. It moves to PREAMBLE, or straight to HEADER when the preamble is skipped. PREAMBLE sends 32 ones and then moves to HEADER. HEADER sends the start pattern, the opcode, the PHY address and the register address (14 bits), then moves to TURN. TURN covers the two turnaround bits and then moves to DATA. DATA covers the 16 data bits and then moves to DONE. DONE lasts one quiet cycle and then returns to IDLE. A soft reset, from any state, returns the sequencer to IDLE.

The register offsets are: 0 control, 1 command, 2 data, 3 status. The management clock is low when idle. Inside each bit period the clock is low for the first half and high for the second half. Output bits change only at the start of a period, which is the falling clock edge.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the control register reads divisor field 39 (bits 16:9), preamble skip 0 (bit 8) and soft reset 0 (bit 0). Status, data and command read 0. The management clock and the output enable are low.
- R2: In the command word, bit 15 requests a read and bit 14 requests a write. Bits 9:5 hold the PHY address and bits 4:0 the register address. A command with both operation bits set, or with neither set, is ignored: busy stays 0 and the command register keeps its last accepted value.
- R3: While busy is set, writes to the command, data and control registers have no effect. The exception is control bit 0.
- R4: Status bit 0 (busy) reads 1 from the cycle after an accepted command. It stays 1 for (P+32)*D+1 cycles, where P is 32, or 0 when the preamble is skipped, and D is the divisor.
- R5: The divisor D equals the control field plus 1; a field of 0 acts as divisor 2. Each bit period lasts D cycles. The clock is low for the first D-floor(D/2) cycles and high for the rest. The clock stays low whenever busy is 0.
- R6: A frame is sent MSB first as follows: 32 ones unless control bit 8 is set, then 01, then the opcode (10 for read, 01 for write), then the 5-bit PHY address, then the 5-bit register address. Each bit changes only at the start of its period.
- R7: A write drives turnaround as 1 then 0 and then the 16 data-register bits, with the output enable high for the whole frame.
- R8: A read releases the line (output enable low) during turnaround and data. It samples the input at each rising clock edge of the 16 data periods. The result is placed in data bits 15:0 when busy clears.
- R9: Writing 1 to control bit 0 makes that bit read 1 in the next cycle. One cycle later every register is back at its reset value, any frame is aborted and the bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for reads and writes |
| reg_wr_data | input | RW (17) | Write data |
| reg_rd_data | output | RW (17) | Read data of the addressed register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data in |

## Verification
Most sequencer, bit-counter or divider faults appear at the ports within one system cycle. A wrong state or index changes the management clock level, the output enable or the driven bit, and these are compared against an independent model on every clock. A read-sampling fault is not visible on the serial pins. It shows only once busy clears, as a wrong data register value. A frame-length fault shows as a busy window with the wrong length.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    // register offsets
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CMD  = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    // field positions
    localparam int CMD_RD_BIT     = 15;
    localparam int CMD_WR_BIT     = 14;
    localparam int CTRL_SRST_BIT  = 0;
    localparam int CTRL_NOPRE_BIT = 8;
    localparam int CTRL_DIV_LSB   = 9;

    // frame segment lengths
    localparam int PRE_BITS = 32;
    localparam int HDR_BITS = 14;
    localparam int TA_BITS  = 2;
    localparam int DAT_BITS = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA,
        ST_DONE
    } mdio_state_e;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter  int DIV_W = 8,
    localparam int CW    = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [DIV_W-1:0] div_m1,
    output logic             mdc,
    output logic             rise_tick,
    output logic             end_tick
);

    logic [CW-1:0] div_full;
    logic [CW-1:0] lo_len;
    logic [CW-1:0] cnt_q;

    // divisor field holds value minus one; zero is raised to two
    always_comb begin
        div_full = (div_m1 == '0) ? CW'(2) : ({1'b0, div_m1} + CW'(1));
        lo_len   = div_full - (div_full >> 1);
    end

    assign end_tick  = run && (cnt_q == div_full - CW'(1));
    assign rise_tick = run && (cnt_q == lo_len - CW'(1));
    assign mdc       = run && (cnt_q >= lo_len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !run || end_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        start,
    input  logic        no_pre,
    input  logic        is_read,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_sel,
    input  logic [15:0] wdata,
    input  logic        rise_tick,
    input  logic        end_tick,
    input  logic        mdio_i,
    output logic        busy,
    output logic        run,
    output logic        done,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rdata
);

    mdio_state_e state_q, state_d;
    logic [4:0]  idx_q;
    logic [15:0] rx_q;
    logic [HDR_BITS-1:0] hdr;
    logic [3:0]  hdr_pos;
    logic [3:0]  dat_pos;

    // state register and bit index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else if (clr) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                idx_q <= '0;
            end else if (end_tick) begin
                idx_q <= idx_q + 5'd1;
            end
        end
    end

    // read shifter, samples at the rising management clock edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (clr) begin
            rx_q <= '0;
        end else if (state_q == ST_DATA && is_read && rise_tick) begin
            rx_q <= {rx_q[14:0], mdio_i};
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = no_pre ? ST_HEADER : ST_PREAMBLE;
            ST_PREAMBLE: if (end_tick && idx_q == 5'(PRE_BITS - 1)) state_d = ST_HEADER;
            ST_HEADER:   if (end_tick && idx_q == 5'(HDR_BITS - 1)) state_d = ST_TURN;
            ST_TURN:     if (end_tick && idx_q == 5'(TA_BITS - 1))  state_d = ST_DATA;
            ST_DATA:     if (end_tick && idx_q == 5'(DAT_BITS - 1)) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    assign hdr     = {2'b01, (is_read ? 2'b10 : 2'b01), phy_addr, reg_sel};
    assign hdr_pos = 4'(HDR_BITS - 1) - idx_q[3:0];
    assign dat_pos = 4'(DAT_BITS - 1) - idx_q[3:0];

    // outputs
    always_comb begin
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        run     = 1'b0;
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_DONE);
        unique case (state_q)
            ST_IDLE: ;
            ST_PREAMBLE: begin
                run     = 1'b1;
                mdio_oe = 1'b1;
                mdio_o  = 1'b1;
            end
            ST_HEADER: begin
                run     = 1'b1;
                mdio_oe = 1'b1;
                mdio_o  = hdr[hdr_pos];
            end
            ST_TURN: begin
                run     = 1'b1;
                mdio_oe = !is_read;
                mdio_o  = (idx_q == 5'd0);
            end
            ST_DATA: begin
                run     = 1'b1;
                mdio_oe = !is_read;
                mdio_o  = wdata[dat_pos];
            end
            ST_DONE: ;
            default: ;
        endcase
    end

    assign rdata = rx_q;

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter  int DIV_W   = 8,
    parameter  int DEF_DIV = 40,
    localparam int RW      = CTRL_DIV_LSB + DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [RW-1:0] reg_wr_data,
    output logic [RW-1:0] reg_rd_data,
    output logic          mdc,
    output logic          mdio_o,
    output logic          mdio_oe,
    input  logic          mdio_i
);

    localparam logic [DIV_W-1:0] DEF_DIV_M1 = DIV_W'(DEF_DIV - 1);

    logic [DIV_W-1:0] div_m1_q;
    logic             nopre_q;
    logic             srst_q;
    logic [15:0]      cmd_q;
    logic [15:0]      data_q;

    logic busy_w, run_w, done_w, rise_w, end_w;
    logic [15:0] rdata_w;
    logic wr_ctrl, wr_cmd, wr_dat, cmd_ok;

    assign wr_ctrl = reg_wr && !srst_q && (reg_addr == A_CTRL);
    assign wr_cmd  = reg_wr && !srst_q && (reg_addr == A_CMD);
    assign wr_dat  = reg_wr && !srst_q && (reg_addr == A_DATA);
    assign cmd_ok  = wr_cmd && !busy_w &&
                     (reg_wr_data[CMD_RD_BIT] ^ reg_wr_data[CMD_WR_BIT]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_m1_q <= DEF_DIV_M1;
            nopre_q  <= 1'b0;
            srst_q   <= 1'b0;
            cmd_q    <= '0;
            data_q   <= '0;
        end else if (srst_q) begin
            div_m1_q <= DEF_DIV_M1;
            nopre_q  <= 1'b0;
            srst_q   <= 1'b0;
            cmd_q    <= '0;
            data_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                if (reg_wr_data[CTRL_SRST_BIT]) begin
                    srst_q <= 1'b1;
                end else if (!busy_w) begin
                    div_m1_q <= reg_wr_data[CTRL_DIV_LSB +: DIV_W];
                    nopre_q  <= reg_wr_data[CTRL_NOPRE_BIT];
                end
            end
            if (cmd_ok) begin
                cmd_q <= reg_wr_data[15:0];
            end
            if (wr_dat && !busy_w) begin
                data_q <= reg_wr_data[15:0];
            end else if (done_w && cmd_q[CMD_RD_BIT]) begin
                data_q <= rdata_w;
            end
        end
    end

    always_comb begin
        reg_rd_data = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rd_data[CTRL_DIV_LSB +: DIV_W] = div_m1_q;
                reg_rd_data[CTRL_NOPRE_BIT]        = nopre_q;
                reg_rd_data[CTRL_SRST_BIT]         = srst_q;
            end
            A_CMD:   reg_rd_data[15:0] = cmd_q;
            A_DATA:  reg_rd_data[15:0] = data_q;
            A_STAT:  reg_rd_data[0]    = busy_w;
            default: reg_rd_data       = '0;
        endcase
    end

    mdio_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (srst_q),
        .run       (run_w),
        .div_m1    (div_m1_q),
        .mdc       (mdc),
        .rise_tick (rise_w),
        .end_tick  (end_w)
    );

    mdio_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (srst_q),
        .start     (cmd_ok),
        .no_pre    (nopre_q),
        .is_read   (cmd_q[CMD_RD_BIT]),
        .phy_addr  (cmd_q[9:5]),
        .reg_sel   (cmd_q[4:0]),
        .wdata     (data_q),
        .rise_tick (rise_w),
        .end_tick  (end_w),
        .mdio_i    (mdio_i),
        .busy      (busy_w),
        .run       (run_w),
        .done      (done_w),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rdata     (rdata_w)
    );

endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk
    import mdio_mgmt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       srst,
    input logic       mdc,
    input logic       mdio_o,
    input logic       mdio_oe,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [1:0] cmd_op
);

    a_r2_bad_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !srst && reg_wr && reg_addr == A_CMD && cmd_op[1] == cmd_op[0]) |=> !busy);

    a_r4_busy_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr && reg_addr == A_CMD && !srst));

    a_r4_quiet_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(srst)) |-> $past(!mdc && !mdio_oe));

    a_r5_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    a_r6_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_oe) && (!mdio_oe || $stable(mdio_o))));

    a_r9_srst_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!srst && !busy));

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy_w),
    .srst     (srst_q),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .cmd_op   (reg_wr_data[15:14])
);

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;

    localparam int RW   = 17;
    localparam int DEFF = 39;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [RW-1:0] reg_wr_data = '0;
    logic [RW-1:0] reg_rd_data;
    logic          mdc, mdio_o, mdio_oe;
    logic          mdio_i = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // behavioural reference model state
    bit        m_busy, m_srst, m_pre_off, m_rd;
    int        m_field, m_div, m_cyc, m_nbits, m_dstart;
    bit [15:0] m_data, m_cmd;
    bit        m_oe [64];
    bit        m_val[64];
    bit [15:0] phy_word = 16'h0000;

    mdio_mgmt_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .mdc         (mdc),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .mdio_i      (mdio_i)
    );

    always #10 clk = ~clk;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic m_defaults();
        m_field = DEFF; m_pre_off = 0; m_data = '0; m_busy = 0;
        m_srst = 0; m_cmd = '0; m_cyc = 0;
    endtask

    task automatic build_frame(bit rd, bit [4:0] phy, bit [4:0] rg);
        int k;
        bit [13:0] h;
        k = 0;
        h = {2'b01, (rd ? 2'b10 : 2'b01), phy, rg};
        if (!m_pre_off) begin
            for (int i = 0; i < 32; i++) begin m_oe[k] = 1; m_val[k] = 1; k++; end
        end
        for (int i = 13; i >= 0; i--) begin m_oe[k] = 1; m_val[k] = h[i]; k++; end
        m_oe[k] = !rd; m_val[k] = 1; k++;
        m_oe[k] = !rd; m_val[k] = 0; k++;
        m_dstart = k;
        for (int i = 15; i >= 0; i--) begin m_oe[k] = !rd; m_val[k] = m_data[i]; k++; end
        m_nbits = k;
    endtask

    // model update on every rising edge
    always @(posedge clk) begin
        bit was_busy;
        if (!rst_n || m_srst) begin
            m_defaults();
        end else begin
            was_busy = m_busy;
            if (m_busy) begin
                if (m_cyc == m_nbits * m_div) begin
                    m_busy = 0;
                    if (m_rd) m_data = phy_word;
                end else begin
                    m_cyc++;
                end
            end
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: if (reg_wr_data[0]) m_srst = 1;
                          else if (!was_busy) begin
                              m_field   = int'(reg_wr_data[16:9]);
                              m_pre_off = reg_wr_data[8];
                          end
                    2'd1: if (!was_busy && (reg_wr_data[15] != reg_wr_data[14])) begin
                              m_cmd  = reg_wr_data[15:0];
                              m_rd   = reg_wr_data[15];
                              m_div  = (m_field == 0) ? 2 : m_field + 1;
                              m_busy = 1;
                              m_cyc  = 0;
                              build_frame(reg_wr_data[15], reg_wr_data[9:5], reg_wr_data[4:0]);
                          end
                    2'd2: if (!was_busy) m_data = reg_wr_data[15:0];
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison of the serial pins, and the PHY's reply
    always @(negedge clk) begin
        int b, ph, lo;
        bit e_mdc, e_oe, e_o;
        string tg;
        if (rst_n && !finished) begin
            e_mdc = 0; e_oe = 0; e_o = 0; tg = "R6";
            mdio_i = 1'b1;
            if (m_busy && m_cyc < m_nbits * m_div) begin
                b  = m_cyc / m_div;
                ph = m_cyc % m_div;
                lo = m_div - m_div / 2;
                e_mdc = (ph >= lo);
                e_oe  = m_oe[b];
                e_o   = m_val[b];
                if (b >= m_dstart - 2) tg = m_rd ? "R8" : "R7";
                if (m_rd && b >= m_dstart) mdio_i = phy_word[15 - (b - m_dstart)];
            end
            check(mdc === e_mdc, "R5", "mdc", int'(mdc), int'(e_mdc));
            check(mdio_oe === e_oe, tg, "mdio_oe", int'(mdio_oe), int'(e_oe));
            if (e_oe) check(mdio_o === e_o, tg, "mdio_o", int'(mdio_o), int'(e_o));
        end
    end

    task automatic wr(logic [1:0] a, int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wr_data = RW'(d);
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd_chk(logic [1:0] a, int exp, string tag);
        @(negedge clk);
        reg_addr = a;
        #1 check(reg_rd_data === RW'(exp), tag, "register read", int'(reg_rd_data), exp);
    endtask

    task automatic count_busy(int exp, string tag);
        int n;
        n = 0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            reg_addr = 2'd3;
            #1;
            if (reg_rd_data[0]) n++;
            else break;
        end
        check(n == exp, tag, "busy length", n, exp);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (!m_busy) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd_chk(2'd0, DEFF << 9, "R1");
        rd_chk(2'd3, 0, "R1");
        rd_chk(2'd2, 0, "R1");
        rd_chk(2'd1, 0, "R1");

        // R5 divisor 2, R7 write frame with preamble, R3 writes while busy
        wr(2'd0, 1 << 9);
        rd_chk(2'd0, 1 << 9, "R5");
        wr(2'd2, 16'hA5C3);
        wr(2'd1, (1 << 14) | (5 << 5) | 26);
        rd_chk(2'd3, 1, "R4");
        wr(2'd1, (1 << 15) | (3 << 5) | 1);
        wr(2'd2, 16'h1111);
        wr(2'd0, 7 << 9);
        rd_chk(2'd1, (1 << 14) | (5 << 5) | 26, "R3");
        rd_chk(2'd0, 1 << 9, "R3");
        wait_idle();
        rd_chk(2'd2, 16'hA5C3, "R3");

        // R4 and R8: read with preamble skipped, divisor 3
        wr(2'd0, (2 << 9) | (1 << 8));
        phy_word = 16'h3C5A;
        wr(2'd1, (1 << 15) | (31 << 5) | 0);
        count_busy(32 * 3 + 1, "R4");
        rd_chk(2'd2, 16'h3C5A, "R8");

        // R2 malformed commands
        wr(2'd1, (3 << 14) | (2 << 5) | 2);
        rd_chk(2'd3, 0, "R2");
        wr(2'd1, (2 << 5) | 2);
        rd_chk(2'd3, 0, "R2");
        rd_chk(2'd1, (1 << 15) | (31 << 5), "R2");

        // R5 zero field behaves as divisor 2
        wr(2'd0, 0);
        rd_chk(2'd0, 0, "R5");
        wr(2'd2, 16'h8001);
        wr(2'd1, (1 << 14) | (17 << 5) | 3);
        count_busy(64 * 2 + 1, "R5");

        // R8 odd divisor 5, full preamble
        wr(2'd0, 4 << 9);
        phy_word = 16'h96E1;
        wr(2'd1, (1 << 15) | (9 << 5) | 30);
        count_busy(64 * 5 + 1, "R8");
        rd_chk(2'd2, 16'h96E1, "R8");

        // R9 soft reset during a frame
        wr(2'd0, 3 << 9);
        wr(2'd2, 16'h0F0F);
        wr(2'd1, (1 << 14) | (1 << 5) | 1);
        repeat (20) @(negedge clk);
        wr(2'd0, 1);
        rd_chk(2'd0, (3 << 9) | 1, "R9");
        rd_chk(2'd3, 0, "R9");
        rd_chk(2'd0, DEFF << 9, "R9");
        rd_chk(2'd2, 0, "R9");

        // R5 default divisor of 40
        wr(2'd2, 16'h5AA5);
        wr(2'd1, (1 << 14) | (4 << 5) | 9);
        count_busy(64 * 40 + 1, "R5");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule